// File: doc/BRIEF.md
# Dual-Issue Dispatch Router

This block sits between an in-order instruction queue and four execution pipes. Each cycle it looks at the two oldest queue entries (slot 0 is the older). For each one it decides whether it can leave the queue, and to which pipe it goes. The four pipes are complex integer, simple integer, load/store and floating point. An instruction leaves only when its source registers are marked ready in the scoreboard and its target pipe's access stage can accept it. Only the older slot may carry the reservation-style memory operations. A conditional store needs the complex-integer and load/store access stages together in the same cycle.

The queue uses `slot_take` in the same cycle to pop entries. The per-pipe launch strobes `pipe_go` and the slot selectors `pipe_slot` leave through one register stage by default, one cycle after the matching `slot_take`. Flexible integer work is balanced between the two integer pipes. A parameter picks which of those pipes is tried first.

Top module: `dsp_router`

## Requirements
- R1: Class codes on `slot_class` (3 bits per slot, slot k at bits [3k+2:3k]) route as follows:
  - 0 = flexible integer.
  - 1 = complex-only, which goes to pipe 0.
  - 2 = memory, which goes to pipe 2.
  - 3 = floating point, which goes to pipe 3.
  - 4 = load-reserve, which goes to pipe 2.
  - 5 = store-conditional.
  - 6 and 7 are handled as complex-only.
  - Pipe bit positions are 0 complex integer, 1 simple integer, 2 load/store, 3 floating point.
- R2: A flexible integer operation (code 0) takes pipe 1 when pipe 1 is available. Otherwise it takes pipe 0 when pipe 0 is available. This is the default order, set by SIMPLE_FIRST=1.
- R3: A store-conditional (code 5) is granted pipes 0 and 2 together in one cycle. It is not dispatched unless both are available.
- R4: Codes 4 and 5 are dispatched only from slot 0. In slot 1 they wait, even when their pipes are free.
- R5: A slot is not dispatched while any of its enabled source registers is not ready in `reg_ready`.
- R6: Issue is in order: slot 1 is never taken in a cycle where slot 0 is not taken.
- R7: A single pipe is never given to both slots. When slot 1 needs a pipe that slot 0 has taken, slot 1 waits; two flexible operations split across pipes 1 and 0.
- R8: When slot 0 writes a register (`lead_dst_en`) that is an enabled source of slot 1, slot 1 waits for a later cycle.
- R9: A pipe is available only while its `pipe_ready` bit is 1 and its `pipe_stall` bit is 0.
- R10: `pipe_go` and `pipe_slot` are registered: they show the grants of the cycle before. `pipe_slot` bit p is 1 when pipe p was fed from slot 1. Reset clears both to zero.
- R11: A slot whose valid bit is 0 is not taken and is granted no pipe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slot_valid | input | 2 | Entry present, per slot |
| slot_class | input | 6 | Class code, 3 bits per slot |
| slot_src | input | 2*NSRC*RW | Source register indices, NSRC per slot |
| slot_src_en | input | 2*NSRC | Source index in use, per source |
| lead_dst | input | RW | Destination register of slot 0 |
| lead_dst_en | input | 1 | Slot 0 writes `lead_dst` |
| pipe_ready | input | 4 | Pipe access stage can accept |
| pipe_stall | input | 4 | Pipe held from downstream |
| reg_ready | input | NREG | Scoreboard, one ready bit per register |
| slot_take | output | 2 | Slot dispatched this cycle (queue pop) |
| pipe_go | output | 4 | Registered launch strobe per pipe |
| pipe_slot | output | 4 | Registered slot selector per pipe |

## Verification
The bench uses the defaults: 32 registers, two sources per slot, the simple pipe tried first and registered outputs. With these settings every class code, every pipe fallback and the slot-1 restrictions can be reached with one pair of queue entries. Register indices are 5 bits wide. This lets the pairwise hazard compare see both matching and non-matching destinations, and a scoreboard bit can be held low on its own to test the operand gating.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
   localparam int NPIPE   = 4;
   localparam int PIPE_CI = 0;
   localparam int PIPE_SI = 1;
   localparam int PIPE_LS = 2;
   localparam int PIPE_FP = 3;
   localparam int CLS_W   = 3;

   typedef enum logic [CLS_W-1:0] {
      CLS_FLEX = 3'd0,
      CLS_CPLX = 3'd1,
      CLS_MEM  = 3'd2,
      CLS_FLT  = 3'd3,
      CLS_RSV  = 3'd4,
      CLS_SCND = 3'd5,
      CLS_X6   = 3'd6,
      CLS_X7   = 3'd7
   } cls_t;

   typedef logic [NPIPE-1:0] pmask_t;

   function automatic pmask_t pbit(input int p);
      pmask_t m;
      m = '0;
      m[p] = 1'b1;
      return m;
   endfunction

   function automatic logic lead_only(input cls_t c);
      return (c == CLS_RSV) || (c == CLS_SCND);
   endfunction
endpackage

// File: rtl/dsp_opnd_chk.sv
module dsp_opnd_chk #(
   parameter int NSRC = 2,
   parameter int NREG = 32,
   localparam int RW  = $clog2(NREG)
) (
   input  logic [NSRC*RW-1:0] src,
   input  logic [NSRC-1:0]    src_en,
   input  logic [NREG-1:0]    reg_ready,
   output logic               ok
);
   logic [NSRC-1:0] each_ok;

   for (genvar j = 0; j < NSRC; j++) begin : g_src
      assign each_ok[j] = !src_en[j] || reg_ready[src[j*RW +: RW]];
   end

   assign ok = &each_ok;
endmodule

// File: rtl/dsp_steer.sv
module dsp_steer
   import dsp_pkg::*;
#(
   parameter int SLOT_ID      = 0,
   parameter bit SIMPLE_FIRST = 1'b1
) (
   input  logic   valid,
   input  cls_t   cls,
   input  logic   opnd_ok,
   input  logic   hold,
   input  pmask_t avail,
   output pmask_t grant,
   output logic   go
);
   localparam int FLEX_A = SIMPLE_FIRST ? PIPE_SI : PIPE_CI;
   localparam int FLEX_B = SIMPLE_FIRST ? PIPE_CI : PIPE_SI;

   pmask_t need;
   logic   fits;
   logic   allowed;

   always_comb begin
      need = '0;
      fits = 1'b0;
      unique case (cls)
         CLS_FLEX: begin
            if (avail[FLEX_A])      need = pbit(FLEX_A);
            else if (avail[FLEX_B]) need = pbit(FLEX_B);
            fits = |need;
         end
         CLS_MEM, CLS_RSV: begin
            need = pbit(PIPE_LS);
            fits = avail[PIPE_LS];
         end
         CLS_FLT: begin
            need = pbit(PIPE_FP);
            fits = avail[PIPE_FP];
         end
         CLS_SCND: begin
            need = pbit(PIPE_CI) | pbit(PIPE_LS);
            fits = avail[PIPE_CI] && avail[PIPE_LS];
         end
         default: begin
            need = pbit(PIPE_CI);
            fits = avail[PIPE_CI];
         end
      endcase
   end

   if (SLOT_ID == 0) begin : g_lead
      assign allowed = 1'b1;
   end else begin : g_trail
      assign allowed = !lead_only(cls);
   end

   assign go    = valid && opnd_ok && !hold && allowed && fits;
   assign grant = go ? need : '0;
endmodule

// File: rtl/dsp_out_stage.sv
module dsp_out_stage
   import dsp_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  pmask_t grant_in,
   input  pmask_t from_trail,
   output pmask_t go_out,
   output pmask_t slot_out
);
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            go_out   <= '0;
            slot_out <= '0;
         end else begin
            go_out   <= grant_in;
            slot_out <= from_trail;
         end
      end

      assert_slot_sub_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (slot_out & ~go_out) == '0)
         else $error("pipe_slot set on an idle pipe");
   end else begin : g_pass
      assign go_out   = grant_in;
      assign slot_out = from_trail;
   end
endmodule

// File: rtl/dsp_router.sv
module dsp_router
   import dsp_pkg::*;
#(
   parameter int NSRC         = 2,
   parameter int NREG         = 32,
   parameter bit SIMPLE_FIRST = 1'b1,
   parameter bit OUT_REG      = 1'b1,
   localparam int RW          = $clog2(NREG)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             slot_valid,
   input  logic [2*CLS_W-1:0]     slot_class,
   input  logic [2*NSRC*RW-1:0]   slot_src,
   input  logic [2*NSRC-1:0]      slot_src_en,
   input  logic [RW-1:0]          lead_dst,
   input  logic                   lead_dst_en,
   input  logic [NPIPE-1:0]       pipe_ready,
   input  logic [NPIPE-1:0]       pipe_stall,
   input  logic [NREG-1:0]        reg_ready,
   output logic [1:0]             slot_take,
   output logic [NPIPE-1:0]       pipe_go,
   output logic [NPIPE-1:0]       pipe_slot
);
   initial begin
      assert (NSRC >= 1) else $error("NSRC must be at least 1");
      assert (NREG >= 2 && (1 << RW) == NREG) else $error("NREG must be a power of two");
   end

   cls_t        cls   [2];
   logic [1:0]  opnd_ok;
   pmask_t      avail0, avail1;
   pmask_t      grant0, grant1;
   logic        go0, go1;
   logic [NSRC-1:0] haz_bit;
   logic        hazard;

   for (genvar k = 0; k < 2; k++) begin : g_slot
      assign cls[k] = cls_t'(slot_class[k*CLS_W +: CLS_W]);
      dsp_opnd_chk #(.NSRC(NSRC), .NREG(NREG)) u_opnd (
         .src       (slot_src[k*NSRC*RW +: NSRC*RW]),
         .src_en    (slot_src_en[k*NSRC +: NSRC]),
         .reg_ready (reg_ready),
         .ok        (opnd_ok[k])
      );

      assert_opnd_R5: assert property (@(posedge clk) disable iff (!rst_n)
         slot_take[k] |-> opnd_ok[k])
         else $error("slot taken with an unready source");
      assert_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
         slot_take[k] |-> slot_valid[k])
         else $error("empty slot taken");
   end

   for (genvar j = 0; j < NSRC; j++) begin : g_haz
      assign haz_bit[j] = lead_dst_en && slot_src_en[NSRC + j]
                       && (slot_src[(NSRC + j)*RW +: RW] == lead_dst);
   end
   assign hazard = |haz_bit;

   assign avail0 = pipe_ready & ~pipe_stall;

   dsp_steer #(.SLOT_ID(0), .SIMPLE_FIRST(SIMPLE_FIRST)) u_lead (
      .valid   (slot_valid[0]),
      .cls     (cls[0]),
      .opnd_ok (opnd_ok[0]),
      .hold    (1'b0),
      .avail   (avail0),
      .grant   (grant0),
      .go      (go0)
   );

   assign avail1 = avail0 & ~grant0;

   dsp_steer #(.SLOT_ID(1), .SIMPLE_FIRST(SIMPLE_FIRST)) u_trail (
      .valid   (slot_valid[1]),
      .cls     (cls[1]),
      .opnd_ok (opnd_ok[1]),
      .hold    (!go0 || hazard),
      .avail   (avail1),
      .grant   (grant1),
      .go      (go1)
   );

   assign slot_take = {go1, go0};

   dsp_out_stage #(.OUT_REG(OUT_REG)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .grant_in   (grant0 | grant1),
      .from_trail (grant1),
      .go_out     (pipe_go),
      .slot_out   (pipe_slot)
   );

   assert_inorder_R6: assert property (@(posedge clk) disable iff (!rst_n)
      slot_take[1] |-> slot_take[0])
      else $error("younger slot issued alone");
   assert_lead_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      slot_take[1] |-> !lead_only(cls[1]))
      else $error("reservation op issued from slot 1");
   assert_avail_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant0 | grant1) & ~(pipe_ready & ~pipe_stall)) == '0)
      else $error("grant to an unavailable pipe");
   assert_disjoint_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant0 & grant1) == '0)
      else $error("pipe granted to both slots");
   assert_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_take[0] && cls[0] == CLS_SCND) |-> (grant0 == (pbit(PIPE_CI) | pbit(PIPE_LS))))
      else $error("store-conditional without both stages");
   assert_hazard_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(slot_take[1] && hazard))
      else $error("dependent pair issued together");
endmodule

// File: tb/dsp_router_test.sv
module dsp_router_test;
   localparam int NSRC = 2;
   localparam int NREG = 32;
   localparam int RW   = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0]           slot_valid;
   logic [5:0]           slot_class;
   logic [2*NSRC*RW-1:0] slot_src;
   logic [2*NSRC-1:0]    slot_src_en;
   logic [RW-1:0]        lead_dst;
   logic                 lead_dst_en;
   logic [3:0]           pipe_ready, pipe_stall;
   logic [NREG-1:0]      reg_ready;
   logic [1:0]           slot_take;
   logic [3:0]           pipe_go, pipe_slot;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   dsp_router uut (
      .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_class(slot_class),
      .slot_src(slot_src), .slot_src_en(slot_src_en), .lead_dst(lead_dst),
      .lead_dst_en(lead_dst_en), .pipe_ready(pipe_ready), .pipe_stall(pipe_stall),
      .reg_ready(reg_ready), .slot_take(slot_take), .pipe_go(pipe_go), .pipe_slot(pipe_slot)
   );

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic idle();
      slot_valid = 2'b00; slot_class = '0; slot_src = '0; slot_src_en = '0;
      lead_dst = '0; lead_dst_en = 1'b0; pipe_ready = 4'hF; pipe_stall = 4'h0;
      reg_ready = '1;
   endtask

   task automatic put(input int k, input logic [2:0] c, input logic [RW-1:0] sa,
                      input logic ea);
      slot_valid[k] = 1'b1;
      slot_class[k*3 +: 3] = c;
      slot_src[(k*NSRC)*RW +: RW] = sa;
      slot_src_en[k*NSRC] = ea;
   endtask

   // Inputs are already set (after a negedge); check take now, grants after the edge.
   task automatic step(input string tag, input logic [1:0] et, input logic [3:0] eg,
                       input logic [3:0] es);
      #1;
      chk({tag, " take"}, {2'b00, slot_take}, {2'b00, et});
      @(posedge clk); #1;
      chk({tag, " go"}, pipe_go, eg);
      chk({tag, " slot"}, pipe_slot, es);
      @(negedge clk);
      idle();
   endtask

   task automatic t_reset();
      chk("R10 reset go", pipe_go, 4'b0000);
      chk("R10 reset slot", pipe_slot, 4'b0000);
   endtask

   task automatic t_route();
      put(0, 3'd3, 5'd0, 1'b0); put(1, 3'd2, 5'd0, 1'b0);
      step("R1 fp+mem", 2'b11, 4'b1100, 4'b0100);
      put(0, 3'd1, 5'd0, 1'b0); put(1, 3'd7, 5'd0, 1'b0);
      step("R1 R7 cplx+code7", 2'b01, 4'b0001, 4'b0000);
      put(0, 3'd6, 5'd0, 1'b0);
      step("R1 code6", 2'b01, 4'b0001, 4'b0000);
      step("R10 idle after", 2'b00, 4'b0000, 4'b0000);
   endtask

   task automatic t_flex();
      put(0, 3'd0, 5'd0, 1'b0);
      step("R2 flex prefers simple", 2'b01, 4'b0010, 4'b0000);
      put(0, 3'd0, 5'd0, 1'b0); pipe_stall[1] = 1'b1;
      step("R2 flex falls back", 2'b01, 4'b0001, 4'b0000);
      put(0, 3'd0, 5'd0, 1'b0); put(1, 3'd0, 5'd0, 1'b0);
      step("R7 two flex split", 2'b11, 4'b0011, 4'b0001);
   endtask

   task automatic t_scnd();
      put(0, 3'd5, 5'd0, 1'b0);
      step("R3 store-cond pair", 2'b01, 4'b0101, 4'b0000);
      put(0, 3'd5, 5'd0, 1'b0); pipe_ready[2] = 1'b0;
      step("R3 store-cond waits", 2'b00, 4'b0000, 4'b0000);
      put(0, 3'd5, 5'd0, 1'b0); put(1, 3'd0, 5'd0, 1'b0);
      step("R3 store-cond + flex", 2'b11, 4'b0111, 4'b0010);
   endtask

   task automatic t_lead_only();
      put(0, 3'd0, 5'd0, 1'b0); put(1, 3'd4, 5'd0, 1'b0);
      step("R4 rsv in slot1", 2'b01, 4'b0010, 4'b0000);
      put(0, 3'd3, 5'd0, 1'b0); put(1, 3'd5, 5'd0, 1'b0);
      step("R4 scnd in slot1", 2'b01, 4'b1000, 4'b0000);
      put(0, 3'd4, 5'd0, 1'b0);
      step("R4 rsv in slot0", 2'b01, 4'b0100, 4'b0000);
   endtask

   task automatic t_opnd();
      put(0, 3'd2, 5'd5, 1'b1); reg_ready[5] = 1'b0;
      step("R5 unready source", 2'b00, 4'b0000, 4'b0000);
      put(0, 3'd3, 5'd5, 1'b1); put(1, 3'd0, 5'd0, 1'b0); reg_ready[5] = 1'b0;
      step("R6 older blocked", 2'b00, 4'b0000, 4'b0000);
      put(0, 3'd3, 5'd5, 1'b1); put(1, 3'd3, 5'd0, 1'b0);
      step("R7 fp conflict", 2'b01, 4'b1000, 4'b0000);
      put(0, 3'd0, 5'd0, 1'b0); put(1, 3'd2, 5'd9, 1'b1); reg_ready[9] = 1'b0;
      step("R5 slot1 unready", 2'b01, 4'b0010, 4'b0000);
   endtask

   task automatic t_hazard();
      put(0, 3'd0, 5'd0, 1'b0); put(1, 3'd2, 5'd7, 1'b1);
      lead_dst = 5'd7; lead_dst_en = 1'b1;
      step("R8 dependent pair", 2'b01, 4'b0010, 4'b0000);
      put(0, 3'd0, 5'd0, 1'b0); put(1, 3'd2, 5'd7, 1'b1);
      lead_dst = 5'd7; lead_dst_en = 1'b0;
      step("R8 no write", 2'b11, 4'b0110, 4'b0100);
      put(0, 3'd0, 5'd0, 1'b0); put(1, 3'd2, 5'd6, 1'b1);
      lead_dst = 5'd7; lead_dst_en = 1'b1;
      step("R8 other reg", 2'b11, 4'b0110, 4'b0100);
   endtask

   task automatic t_avail();
      put(0, 3'd3, 5'd0, 1'b0); pipe_stall[3] = 1'b1;
      step("R9 stalled", 2'b00, 4'b0000, 4'b0000);
      put(0, 3'd3, 5'd0, 1'b0); pipe_ready[3] = 1'b0;
      step("R9 not ready", 2'b00, 4'b0000, 4'b0000);
      put(0, 3'd0, 5'd0, 1'b0); pipe_stall[1] = 1'b1; pipe_ready[0] = 1'b0;
      step("R9 R2 no integer pipe", 2'b00, 4'b0000, 4'b0000);
   endtask

   task automatic t_invalid();
      put(0, 3'd3, 5'd0, 1'b0); put(1, 3'd2, 5'd0, 1'b0); slot_valid[0] = 1'b0;
      step("R11 empty slot0", 2'b00, 4'b0000, 4'b0000);
   endtask

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #1 t_reset();
      @(negedge clk) rst_n = 1'b1;
      t_route();
      t_flex();
      t_scnd();
      t_lead_only();
      t_opnd();
      t_hazard();
      t_avail();
      t_invalid();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule